// File: doc/BRIEF.md
# Masked Latching Error Aggregator

This block gathers six error flags from the signal path of an incremental-encoder interpolator and folds them into one active-low global error output. An 8-bit control word enables each source individually. The same word also carries two control bits. One asks for the quadrature A/B and reference outputs to be frozen while an error is present. The other makes every enabled error sticky until it is cleared.

A single-cycle clear strobe empties the sticky copies. This strobe comes from the reset-count command (code 0x01) of the serial command decoder. Any assertion of the error output lasts at least eight clocks. The output can therefore be wired back to the chip's reset input and still give a clean resynchronisation pulse, even when the reset removes the cause at once.

Next to the global output, the block presents the raw error flags as a status word, along with two group flags. The sensor group flag covers breakage-like conditions. The amplitude group flag covers signal-level conditions.

Top module: `err_aggregator`

## Requirements
- R1: After reset the control word is 0x00, `err_n` is 1 and `freeze` is 0.
- R2: Source bit i is enabled when control bit i (i = 0..5) is 1. One clock edge after an enabled flag is seen, `err_n` is 0. A flag whose control bit is 0 never drives `err_n` low.
- R3: Control bit 6 is the hold control. When it is 1, an active enabled error sets `freeze` to 1 at the next edge. When it is 0, `freeze` stays 0.
- R4: Control bit 7 is the sticky control. When it is 1, an enabled flag is stored once seen and keeps `err_n` low after the raw flag drops, until a clear or a reset.
- R5: A one-cycle pulse on `clr_stb` empties the stored flags. If a flag is enabled and active in the same cycle as the clear, that flag stays stored.
- R6: Flag bit order: 0 gain controller at limit, 1 offset controller at limit, 2 amplitude too small, 3 ADC clipping, 4 too fast for direction recognition, 5 too fast for A/B/reference generation. `sens_err` is the OR of bits 0..3. `amp_err` is the OR of bits 2..3. Both are registered one cycle after the raw flags.
- R7: Once `err_n` goes low, it stays low for at least 8 clocks. After a one-cycle cause, it returns high at the 8th edge after its fall.
- R8: `status` shows all six raw flags one cycle later, whatever the control word holds.
- R9: With bit 7 at 0, nothing is stored. `err_n` returns high once the cause is gone and the minimum pulse has ended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low chip reset |
| err_flags | input | 6 | Raw error flags, order as in R6 |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 8 | Control word: bits 0..5 source enables, 6 hold, 7 sticky |
| clr_stb | input | 1 | One-cycle clear of the stored flags (reset-count command) |
| err_n | output | 1 | Global error, active low, stretched to at least 8 clocks |
| freeze | output | 1 | Registered request to hold the A/B/reference outputs |
| status | output | 6 | Registered raw flags |
| sens_err | output | 1 | Sensor group flag |
| amp_err | output | 1 | Amplitude group flag |

## Verification
The bench targets the same-cycle race between a clear and a new error. A design that let the clear win would drop the sticky bit and release `err_n` too early. It also measures the exact edge on which a stretched pulse ends, which catches off-by-one counters that give 7 or 9 clocks. Further cases cover flags that are masked off but still show in `status` and the group flags, and freeze requests with the hold bit cleared. Faulty masking, a wrong group composition, or a freeze that ignores bit 6 would show up directly on the outputs.

// File: rtl/err_aggr_pkg.sv
package err_aggr_pkg;
  localparam int SRC_CNT        = 6;
  localparam int IDX_GAIN_LIM   = 0;
  localparam int IDX_OFFS_LIM   = 1;
  localparam int IDX_AMPL_LOW   = 2;
  localparam int IDX_ADC_CLIP   = 3;
  localparam int IDX_FAST_DIR   = 4;
  localparam int IDX_FAST_GEN   = 5;
  localparam int CTRL_HOLD_BIT  = SRC_CNT;
  localparam int CTRL_STICK_BIT = SRC_CNT + 1;
  localparam int CTRL_W         = SRC_CNT + 2;
  localparam int MIN_PULSE      = 8;
endpackage

// File: rtl/eagg_ctrl_reg.sv
module eagg_ctrl_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r, q_nxt;

  always_comb begin
    q_nxt = q_r;
    if (we) q_nxt = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q = q_r;

  p_reset_value_r1: assert property (@(posedge clk) $rose(rst_n) |-> (q_r == '0));
endmodule

// File: rtl/eagg_store.sv
module eagg_store #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stick_en,
  input  logic         clr,
  input  logic [N-1:0] enables,
  input  logic [N-1:0] gated,
  output logic [N-1:0] effective
);
  logic [N-1:0] held_r;

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic held_nxt;

    always_comb begin
      held_nxt = 1'b0;
      if (stick_en) held_nxt = (held_r[i] & ~clr) | gated[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) held_r[i] <= 1'b0;
      else        held_r[i] <= held_nxt;
    end

    assign effective[i] = gated[i] | (stick_en & held_r[i] & enables[i]);

    p_keep_stored_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stick_en && held_r[i] && !clr) |=> held_r[i]);
    p_new_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (stick_en && clr && gated[i]) |=> held_r[i]);
    p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !gated[i]) |=> !held_r[i]);
    p_no_store_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !stick_en |=> !held_r[i]);
  end
endmodule

// File: rtl/eagg_stretch.sv
module eagg_stretch #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);
  localparam int CNT_W = (LEN > 2) ? $clog2(LEN) : 1;
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(LEN - 1);

  logic [CNT_W-1:0] cnt_r, cnt_nxt;
  logic             act_r, act_nxt;

  always_comb begin
    act_nxt = trig | (cnt_r != '0);
    cnt_nxt = cnt_r;
    if (trig)              cnt_nxt = LOAD;
    else if (cnt_r != '0)  cnt_nxt = cnt_r - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_r <= '0;
      act_r <= 1'b0;
    end else begin
      cnt_r <= cnt_nxt;
      act_r <= act_nxt;
    end
  end

  assign active = act_r;

  p_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (act_r && cnt_r == LOAD));
  p_min_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_r && cnt_r != '0) |=> act_r);
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && cnt_r == '0) |=> !act_r);
endmodule

// File: rtl/eagg_status.sv
module eagg_status #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  output logic [N-1:0] status,
  output logic         sens,
  output logic         ampl
);
  import err_aggr_pkg::*;

  logic [N-1:0] st_r;
  logic         sens_r, ampl_r, sens_nxt, ampl_nxt;

  always_comb begin
    ampl_nxt = raw[IDX_ADC_CLIP] | raw[IDX_AMPL_LOW];
    sens_nxt = ampl_nxt | raw[IDX_OFFS_LIM] | raw[IDX_GAIN_LIM];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r   <= '0;
      sens_r <= 1'b0;
      ampl_r <= 1'b0;
    end else begin
      st_r   <= raw;
      sens_r <= sens_nxt;
      ampl_r <= ampl_nxt;
    end
  end

  assign status = st_r;
  assign sens   = sens_r;
  assign ampl   = ampl_r;

  p_amp_in_sens_r6: assert property (@(posedge clk) disable iff (!rst_n) ampl_r |-> sens_r);
  p_sens_from_status_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sens_r == (|st_r[IDX_ADC_CLIP:IDX_GAIN_LIM]));
endmodule

// File: rtl/err_aggregator.sv
module err_aggregator
  import err_aggr_pkg::*;
#(
  parameter int N_SRC     = SRC_CNT,
  parameter int PULSE_LEN = MIN_PULSE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] err_flags,
  input  logic             ctrl_we,
  input  logic [N_SRC+1:0] ctrl_wdata,
  input  logic             clr_stb,
  output logic             err_n,
  output logic             freeze,
  output logic [N_SRC-1:0] status,
  output logic             sens_err,
  output logic             amp_err
);
  localparam int CW = N_SRC + 2;

  logic [CW-1:0]    ctrl;
  logic [N_SRC-1:0] enables, gated, effective;
  logic             hold_en, stick_en, any_err, err_act;
  logic             frz_r, frz_nxt;

  eagg_ctrl_reg #(.W(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata), .q(ctrl)
  );

  assign enables  = ctrl[N_SRC-1:0];
  assign hold_en  = ctrl[N_SRC];
  assign stick_en = ctrl[N_SRC+1];
  assign gated    = err_flags & enables;

  eagg_store #(.N(N_SRC)) u_store (
    .clk(clk), .rst_n(rst_n), .stick_en(stick_en), .clr(clr_stb),
    .enables(enables), .gated(gated), .effective(effective)
  );

  assign any_err = |effective;

  eagg_stretch #(.LEN(PULSE_LEN)) u_stretch (
    .clk(clk), .rst_n(rst_n), .trig(any_err), .active(err_act)
  );

  always_comb frz_nxt = hold_en & any_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frz_r <= 1'b0;
    else        frz_r <= frz_nxt;
  end

  eagg_status #(.N(N_SRC)) u_status (
    .clk(clk), .rst_n(rst_n), .raw(err_flags),
    .status(status), .sens(sens_err), .ampl(amp_err)
  );

  assign err_n  = ~err_act;
  assign freeze = frz_r;

  p_flag_to_err_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(err_flags & enables)) |=> !err_n);
  p_freeze_on_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_en && any_err) |=> freeze);
  p_freeze_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_en |=> !freeze);
  p_freeze_implies_err_r3: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |-> !err_n);
endmodule

// File: tb/err_aggregator_test.sv
module err_aggregator_test;
  logic       clk, rst_n;
  logic [5:0] err_flags;
  logic       ctrl_we, clr_stb;
  logic [7:0] ctrl_wdata;
  logic       err_n, freeze, sens_err, amp_err;
  logic [5:0] status;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  typedef struct {
    string      tag;
    int         kind;   // 0 err_n, 1 freeze, 2 status+groups
    logic       v;
    logic [5:0] st;
    logic       se;
    logic       am;
  } item_t;

  item_t sb[$];

  err_aggregator uut (
    .clk(clk), .rst_n(rst_n), .err_flags(err_flags), .ctrl_we(ctrl_we),
    .ctrl_wdata(ctrl_wdata), .clr_stb(clr_stb), .err_n(err_n), .freeze(freeze),
    .status(status), .sens_err(sens_err), .amp_err(amp_err)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic fail_line(string tag, string what, int act, int exp);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  // monitor: compares everything queued for this edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        checks++;
        case (it.kind)
          0: if (err_n !== it.v) fail_line(it.tag, "err_n", int'(err_n), int'(it.v));
          1: if (freeze !== it.v) fail_line(it.tag, "freeze", int'(freeze), int'(it.v));
          default: if (status !== it.st || sens_err !== it.se || amp_err !== it.am)
            fail_line(it.tag, "status/sens/amp", int'({status, sens_err, amp_err}),
                      int'({it.st, it.se, it.am}));
        endcase
      end
    end
  end

  task automatic step(input logic [5:0] f, input logic c, input logic w, input logic [7:0] d);
    @(negedge clk);
    err_flags = f; clr_stb = c; ctrl_we = w; ctrl_wdata = d;
  endtask

  task automatic exp_err(string tag, logic v);
    item_t it; it.tag = tag; it.kind = 0; it.v = v; it.st = '0; it.se = 0; it.am = 0;
    sb.push_back(it);
  endtask

  task automatic exp_frz(string tag, logic v);
    item_t it; it.tag = tag; it.kind = 1; it.v = v; it.st = '0; it.se = 0; it.am = 0;
    sb.push_back(it);
  endtask

  task automatic exp_st(string tag, logic [5:0] s, logic se, logic am);
    item_t it; it.tag = tag; it.kind = 2; it.v = 0; it.st = s; it.se = se; it.am = am;
    sb.push_back(it);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(6'h00, 0, 0, 8'h00);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    rst_n = 0; err_flags = 0; clr_stb = 0; ctrl_we = 0; ctrl_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    step(6'h00, 0, 0, 8'h00);
    exp_err("R1", 1); exp_frz("R1", 0); exp_st("R1", 6'h00, 0, 0);

    // R8, R2: all raw flags with mask 0 -> status only
    step(6'h3F, 0, 0, 8'h00);
    exp_st("R8", 6'h3F, 1, 1); exp_err("R2 masked off", 1);
    // R6 groups
    step(6'h08, 0, 0, 8'h00); exp_st("R6 clip", 6'h08, 1, 1);
    step(6'h02, 0, 0, 8'h00); exp_st("R6 offset", 6'h02, 1, 0);
    step(6'h10, 0, 0, 8'h00); exp_st("R6 fast", 6'h10, 0, 0);
    step(6'h04, 0, 0, 8'h00); exp_st("R6 ampl", 6'h04, 1, 1);
    step(6'h01, 0, 0, 8'h00); exp_st("R6 gain", 6'h01, 1, 0); exp_err("R2 masked off", 1);

    // enable sources, no hold, no sticky
    step(6'h00, 0, 1, 8'h3F); exp_err("R2", 1);
    step(6'h01, 0, 0, 8'h00); exp_err("R2", 0); exp_frz("R3 hold off", 0);
    for (int k = 0; k < 7; k++) begin
      step(6'h00, 0, 0, 8'h00); exp_err("R7 stretch", 0);
    end
    step(6'h00, 0, 0, 8'h00); exp_err("R7 end", 1);
    step(6'h00, 0, 0, 8'h00); exp_err("R9", 1);

    // R3 hold
    step(6'h00, 0, 1, 8'h7F);
    step(6'h20, 0, 0, 8'h00); exp_err("R3", 0); exp_frz("R3", 1);
    step(6'h00, 0, 0, 8'h00); exp_frz("R3 release", 0);
    idle(9); exp_err("R9", 1);

    // R4 sticky
    step(6'h00, 0, 1, 8'hBF);
    step(6'h04, 0, 0, 8'h00); exp_err("R4", 0);
    idle(20); exp_err("R4 held", 0); exp_frz("R3 hold off", 0);
    // R5 clear
    step(6'h00, 1, 0, 8'h00);
    idle(7); exp_err("R5 stretch after clear", 0);
    step(6'h00, 0, 0, 8'h00); exp_err("R5 cleared", 1);

    // R5 clear and new error in the same cycle
    step(6'h02, 0, 0, 8'h00);
    step(6'h02, 1, 0, 8'h00);
    idle(12); exp_err("R5 new wins", 0);
    step(6'h00, 1, 0, 8'h00);
    idle(8); exp_err("R5 cleared", 1);

    // R2 masked-off source with sticky enabled
    step(6'h00, 0, 1, 8'h81);
    step(6'h02, 0, 0, 8'h00); exp_err("R2 sticky masked", 1);
    idle(10); exp_err("R2 sticky masked", 1);

    @(posedge clk); #3;
    done = 1;
    summary();
  end
endmodule